// File: doc/BRIEF.md
# Power Domain Gating Sequencer

This block removes and restores power for one switchable island of a chip, for example a graphics and video region. Software requests a transition by writing the control register over a simple APB-style bus. The block then runs a timed two-phase sequence that drives the island's isolation enable and its power-switch enable, and pulses a completion strobe at the end.

Power-down raises isolation first and waits two programmed delays before it opens the switch. Power-up closes the switch first and waits two programmed delays before it drops isolation. All delays are 6-bit counts of the bus clock. The switch opens only when the island's gating permission bit is set. With the permission bit clear, a power-down runs its full timing and completes, but power stays on.

The sequencer has five states. ST_IDLE waits for a request. ST_DN_ISO holds the isolation delay and ST_DN_SW holds the isolation-to-switch delay. ST_UP_SW holds the switch-on delay and ST_UP_ISO holds the switch-to-isolation delay. The transitions are as follows:
- ST_IDLE goes to ST_UP_SW when power-up is requested.
- ST_IDLE goes to ST_DN_ISO when only power-down is requested.
- ST_DN_ISO goes to ST_DN_SW, and ST_UP_SW goes to ST_UP_ISO, when the running phase count expires.
- ST_DN_SW and ST_UP_ISO return to ST_IDLE when their count expires. That return opens the switch (power-down) or drops isolation (power-up) and pulses done.

Top module: `pwr_island_seq`

## Requirements
- R1: After reset, pwr_on=1, iso_en=0, busy=0 and done=0. Both timing registers (0x264 and 0x268) read 0x0101. The gating register (0x260) reads 0 and the control register (0x000) reads 0.
- R2: Gating register 0x260: bit 0 is the gating permission and all other bits read 0. Power-up timing register 0x264: bits [5:0] hold the switch-on delay and bits [13:8] hold the switch-to-isolation delay. Power-down timing register 0x268: bits [5:0] hold the isolation delay and bits [13:8] hold the isolation-to-switch delay. Unused bits of both timing registers read 0.
- R3: A control write with bit 0 set and bit 1 clear, accepted at clock edge E0, raises iso_en at E0. With gating permitted, pwr_on falls exactly isolation delay plus isolation-to-switch delay edges after E0, and not earlier.
- R4: With the gating permission bit at 0, a power-down still asserts iso_en and completes after the same time, but pwr_on stays 1.
- R5: A control write with bit 1 set, accepted at E0, drives pwr_on to 1 at E0. iso_en falls exactly switch-on delay plus switch-to-isolation delay edges after E0.
- R6: A delay field of 0 counts as one cycle, so a sequence with both fields at 0 completes two edges after acceptance.
- R7: busy is 1 from the acceptance edge until the final edge of the sequence, and control bit 31 reads it. done is a single-cycle pulse at that final edge, in the cycle where busy has already returned to 0.
- R8: While a sequence runs, control bit 0 (power-down) or bit 1 (power-up) reads 1. The bit clears itself when the sequence ends.
- R9: A control write with both bit 0 and bit 1 set runs a power-up.
- R10: A control write accepted while busy is 1 is ignored. No extra sequence runs and the outputs follow only the running sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all delays count this clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Register select |
| penable | input | 1 | Access phase; a write is taken when psel, penable and pwrite are all 1 |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Register byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while psel=1 and pwrite=0 |
| iso_en | output | 1 | Isolation enable for the island |
| pwr_on | output | 1 | Power-switch enable; 1 = island powered |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse when a sequence completes |

## Verification
Two pairs of events can land in the same cycle. The first is a control write that carries both request bits at once. The bench writes both bits while the island is off and judges that the switch closes at the acceptance edge and that isolation drops after the power-up delays, not the power-down ones. The second is a new request that arrives while a sequence is running. The bench issues requests in both directions in the middle of a long power-down. A scoreboard holds exactly one expected completion. Any extra done pulse, or any change to the final switch and isolation levels some 40 cycles later, counts as a failure.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DN_ISO,
        ST_DN_SW,
        ST_UP_SW,
        ST_UP_ISO
    } pgs_state_e;

    localparam logic [11:0] OFF_CTRL   = 12'h000;
    localparam logic [11:0] OFF_GATE   = 12'h260;
    localparam logic [11:0] OFF_UP_TIM = 12'h264;
    localparam logic [11:0] OFF_DN_TIM = 12'h268;

    localparam int HI_FIELD_LSB = 8;

endpackage

// File: rtl/pgs_timer.sv
module pgs_timer #(
    parameter int DLY_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    output logic             expire
);
    logic [DLY_W-1:0] cnt_q;
    logic [DLY_W-1:0] eff_val;

    // a zero field still costs one cycle
    assign eff_val = (load_val == '0) ? DLY_W'(1) : load_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= eff_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - DLY_W'(1);
        end
    end

    assign expire = (cnt_q == DLY_W'(1));

endmodule

// File: rtl/pgs_regs.sv
module pgs_regs
    import pgs_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int DLY_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic              busy,
    input  logic              run_dn,
    input  logic              run_up,
    output logic              ctrl_wr,
    output logic              dn_req,
    output logic              up_req,
    output logic              gate_en,
    output logic [DLY_W-1:0]  up_sw_dly,
    output logic [DLY_W-1:0]  up_iso_dly,
    output logic [DLY_W-1:0]  dn_iso_dly,
    output logic [DLY_W-1:0]  dn_sw_dly
);
    localparam int HI_LSB  = HI_FIELD_LSB;
    localparam int GAP_W   = HI_LSB - DLY_W;
    localparam int TOP_W   = DATA_W - HI_LSB - DLY_W;
    localparam int CTRL_PAD = DATA_W - 3;

    logic wr_acc;
    logic sel_ctrl, sel_gate, sel_up, sel_dn;
    logic unused_wdata;

    assign wr_acc   = psel && penable && pwrite;
    assign sel_ctrl = (paddr == ADDR_W'(OFF_CTRL));
    assign sel_gate = (paddr == ADDR_W'(OFF_GATE));
    assign sel_up   = (paddr == ADDR_W'(OFF_UP_TIM));
    assign sel_dn   = (paddr == ADDR_W'(OFF_DN_TIM));

    assign ctrl_wr = wr_acc && sel_ctrl;
    assign dn_req  = pwdata[0];
    assign up_req  = pwdata[1];
    assign unused_wdata = ^pwdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_en    <= 1'b0;
            up_sw_dly  <= DLY_W'(1);
            up_iso_dly <= DLY_W'(1);
            dn_iso_dly <= DLY_W'(1);
            dn_sw_dly  <= DLY_W'(1);
        end else if (wr_acc) begin
            if (sel_gate) begin
                gate_en <= pwdata[0];
            end
            if (sel_up) begin
                up_sw_dly  <= pwdata[DLY_W-1:0];
                up_iso_dly <= pwdata[HI_LSB+DLY_W-1:HI_LSB];
            end
            if (sel_dn) begin
                dn_iso_dly <= pwdata[DLY_W-1:0];
                dn_sw_dly  <= pwdata[HI_LSB+DLY_W-1:HI_LSB];
            end
        end
    end

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            if (sel_ctrl) begin
                prdata = {busy, {CTRL_PAD{1'b0}}, run_up, run_dn};
            end else if (sel_gate) begin
                prdata = {{(DATA_W-1){1'b0}}, gate_en};
            end else if (sel_up) begin
                prdata = {{TOP_W{1'b0}}, up_iso_dly, {GAP_W{1'b0}}, up_sw_dly};
            end else if (sel_dn) begin
                prdata = {{TOP_W{1'b0}}, dn_sw_dly, {GAP_W{1'b0}}, dn_iso_dly};
            end
        end
    end

endmodule

// File: rtl/pgs_fsm.sv
module pgs_fsm
    import pgs_pkg::*;
#(
    parameter int DLY_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             dn_req,
    input  logic             up_req,
    input  logic             gate_en,
    input  logic [DLY_W-1:0] up_sw_dly,
    input  logic [DLY_W-1:0] up_iso_dly,
    input  logic [DLY_W-1:0] dn_iso_dly,
    input  logic [DLY_W-1:0] dn_sw_dly,
    input  logic             expire,
    output logic             timer_load,
    output logic [DLY_W-1:0] timer_val,
    output logic             iso_en,
    output logic             pwr_on,
    output logic             done,
    output logic             busy,
    output logic             run_dn,
    output logic             run_up
);
    pgs_state_e state_q, state_nxt;
    logic start_up, start_dn;

    // power-up wins when both bits arrive together
    assign start_up = ctrl_wr && up_req && (state_q == ST_IDLE);
    assign start_dn = ctrl_wr && dn_req && !up_req && (state_q == ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    always_comb begin
        state_nxt  = state_q;
        timer_load = 1'b0;
        timer_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_up) begin
                    state_nxt  = ST_UP_SW;
                    timer_load = 1'b1;
                    timer_val  = up_sw_dly;
                end else if (start_dn) begin
                    state_nxt  = ST_DN_ISO;
                    timer_load = 1'b1;
                    timer_val  = dn_iso_dly;
                end
            end
            ST_DN_ISO: begin
                if (expire) begin
                    state_nxt  = ST_DN_SW;
                    timer_load = 1'b1;
                    timer_val  = dn_sw_dly;
                end
            end
            ST_DN_SW: begin
                if (expire) state_nxt = ST_IDLE;
            end
            ST_UP_SW: begin
                if (expire) begin
                    state_nxt  = ST_UP_ISO;
                    timer_load = 1'b1;
                    timer_val  = up_iso_dly;
                end
            end
            ST_UP_ISO: begin
                if (expire) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iso_en <= 1'b0;
            pwr_on <= 1'b1;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_up) begin
                        pwr_on <= 1'b1;
                    end else if (start_dn) begin
                        iso_en <= 1'b1;
                    end
                end
                ST_DN_SW: begin
                    if (expire) begin
                        if (gate_en) pwr_on <= 1'b0;
                        done <= 1'b1;
                    end
                end
                ST_UP_ISO: begin
                    if (expire) begin
                        iso_en <= 1'b0;
                        done   <= 1'b1;
                    end
                end
                ST_DN_ISO, ST_UP_SW: ;
                default: ;
            endcase
        end
    end

    assign busy   = (state_q != ST_IDLE);
    assign run_dn = (state_q == ST_DN_ISO) || (state_q == ST_DN_SW);
    assign run_up = (state_q == ST_UP_SW) || (state_q == ST_UP_ISO);

endmodule

// File: rtl/pwr_island_seq.sv
module pwr_island_seq #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int DLY_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              iso_en,
    output logic              pwr_on,
    output logic              busy,
    output logic              done
);
    logic             ctrl_wr, dn_req, up_req, gate_en;
    logic [DLY_W-1:0] up_sw_dly, up_iso_dly, dn_iso_dly, dn_sw_dly;
    logic             timer_load, expire;
    logic [DLY_W-1:0] timer_val;
    logic             run_dn, run_up;

    pgs_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DLY_W(DLY_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .busy(busy), .run_dn(run_dn), .run_up(run_up),
        .ctrl_wr(ctrl_wr), .dn_req(dn_req), .up_req(up_req),
        .gate_en(gate_en),
        .up_sw_dly(up_sw_dly), .up_iso_dly(up_iso_dly),
        .dn_iso_dly(dn_iso_dly), .dn_sw_dly(dn_sw_dly)
    );

    pgs_timer #(.DLY_W(DLY_W)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .load(timer_load), .load_val(timer_val), .expire(expire)
    );

    pgs_fsm #(.DLY_W(DLY_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(ctrl_wr), .dn_req(dn_req), .up_req(up_req),
        .gate_en(gate_en),
        .up_sw_dly(up_sw_dly), .up_iso_dly(up_iso_dly),
        .dn_iso_dly(dn_iso_dly), .dn_sw_dly(dn_sw_dly),
        .expire(expire),
        .timer_load(timer_load), .timer_val(timer_val),
        .iso_en(iso_en), .pwr_on(pwr_on), .done(done),
        .busy(busy), .run_dn(run_dn), .run_up(run_up)
    );

endmodule

// File: rtl/pgs_checker.sv
module pgs_checker (
    input logic clk,
    input logic rst_n,
    input logic iso_en,
    input logic pwr_on,
    input logic busy,
    input logic done,
    input logic run_dn,
    input logic run_up
);
    AST_OFF_IMPLIES_ISO: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |-> iso_en); // R3

    AST_SWITCH_OPEN_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_on) |-> done); // R3

    AST_ISO_DROP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iso_en) |-> (done && pwr_on)); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R7

    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({run_up, run_dn})); // R8

    AST_REQ_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable({run_up, run_dn})); // R10

endmodule

bind pwr_island_seq pgs_checker u_pgs_checker (
    .clk(clk), .rst_n(rst_n), .iso_en(iso_en), .pwr_on(pwr_on),
    .busy(busy), .done(done), .run_dn(run_dn), .run_up(run_up)
);

// File: tb/pwr_island_seq_bench.sv
`timescale 1ns/1ps
module pwr_island_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        iso_en, pwr_on, busy, done;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 0;

    typedef struct {
        int    at;
        logic  iso;
        logic  pwr;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwr_island_seq u_pwr_island_seq (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .iso_en(iso_en), .pwr_on(pwr_on), .busy(busy), .done(done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int eff(input int d);
        return (d == 0) ? 1 : d;
    endfunction

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] d, output int c0);
        @(negedge clk);
        psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge clk);
        penable = 1;
        @(negedge clk);
        c0 = cyc;
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1; pwrite = 0; paddr = a;
        #1 d = prdata;
        psel = 0;
    endtask

    // driver: start a sequence and post its expected completion
    task automatic start_seq(input logic [31:0] ctrl, input int d1, input int d2,
                             input logic iso_f, input logic pwr_f, input string tag,
                             output int c0);
        apb_wr(12'h000, ctrl, c0);
        sb.push_back('{c0 + eff(d1) + eff(d2), iso_f, pwr_f, tag});
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy || sb.size() != 0);
        @(negedge clk);
        chk("R7 done low after pulse", done, 0);
    endtask

    // monitor: pop and compare on every completion pulse
    logic last_done = 0;
    always @(negedge clk) begin
        if (rst_n && done) begin
            chk("R7 done one cycle", last_done, 0);
            chk("R7 busy low at done", busy, 0);
            if (sb.size() == 0) begin
                chk("R10 unexpected completion", 1, 0);
            end else begin
                exp_t it;
                it = sb.pop_front();
                chk({it.tag, " completion cycle"}, cyc, it.at);
                chk({it.tag, " final iso_en"}, iso_en, it.iso);
                chk({it.tag, " final pwr_on"}, pwr_on, it.pwr);
            end
        end
        last_done <= done;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        if (!finished) $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int c0, dummy;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pwr_on", pwr_on, 1);
        chk("R1 iso_en", iso_en, 0);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        apb_rd(12'h264, rd); chk("R1 up timing", rd, 32'h0101);
        apb_rd(12'h268, rd); chk("R1 down timing", rd, 32'h0101);
        apb_rd(12'h260, rd); chk("R1 gate", rd, 0);
        apb_rd(12'h000, rd); chk("R1 ctrl", rd, 0);

        // R2 field widths
        apb_wr(12'h264, 32'hFFFF_FFFF, dummy);
        apb_rd(12'h264, rd); chk("R2 up timing fields", rd, 32'h3F3F);
        apb_wr(12'h268, 32'hFFFF_FFFF, dummy);
        apb_rd(12'h268, rd); chk("R2 down timing fields", rd, 32'h3F3F);
        apb_wr(12'h260, 32'hFFFF_FFFE, dummy);
        apb_rd(12'h260, rd); chk("R2 gate bit0 only", rd, 0);
        apb_wr(12'h264, 32'h0101, dummy);
        apb_wr(12'h268, 32'h0101, dummy);

        // R4 power-down with gating disallowed
        start_seq(32'h1, 1, 1, 1, 1, "R4 no-gate down", c0);
        chk("R4 iso at accept", iso_en, 1);
        wait_idle();

        // R3 R7 R8 power-down with gating allowed
        apb_wr(12'h260, 32'h1, dummy);
        apb_wr(12'h268, 32'h0503, dummy);
        start_seq(32'h1, 3, 5, 1, 0, "R3 gated down", c0);
        chk("R3 iso at accept", iso_en, 1);
        chk("R7 busy at accept", busy, 1);
        apb_rd(12'h000, rd); chk("R8 R7 ctrl during down", rd, 32'h8000_0001);
        while (cyc < c0 + 7) @(negedge clk);
        chk("R3 switch not yet open", pwr_on, 1);
        wait_idle();
        apb_rd(12'h000, rd); chk("R8 ctrl cleared", rd, 0);

        // R5 power-up
        apb_wr(12'h264, 32'h0204, dummy);
        start_seq(32'h2, 4, 2, 0, 1, "R5 up", c0);
        chk("R5 switch at accept", pwr_on, 1);
        chk("R5 iso held at accept", iso_en, 1);
        apb_rd(12'h000, rd); chk("R8 ctrl during up", rd, 32'h8000_0002);
        wait_idle();

        // R6 zero delays
        apb_wr(12'h268, 32'h0, dummy);
        start_seq(32'h1, 0, 0, 1, 0, "R6 zero down", c0);
        wait_idle();
        apb_wr(12'h264, 32'h0, dummy);
        start_seq(32'h2, 0, 0, 0, 1, "R6 zero up", c0);
        wait_idle();

        // R9 both bits: island off first, then both requests together
        start_seq(32'h1, 0, 0, 1, 0, "R9 setup down", c0);
        wait_idle();
        apb_wr(12'h264, 32'h0101, dummy);
        start_seq(32'h3, 1, 1, 0, 1, "R9 both bits", c0);
        chk("R9 switch closes at accept", pwr_on, 1);
        apb_rd(12'h000, rd); chk("R9 ctrl shows up", rd, 32'h8000_0002);
        wait_idle();

        // R10 requests while busy are dropped
        apb_wr(12'h268, 32'h1010, dummy);
        start_seq(32'h1, 16, 16, 1, 0, "R10 long down", c0);
        apb_wr(12'h000, 32'h2, dummy);
        apb_wr(12'h000, 32'h3, dummy);
        apb_rd(12'h000, rd); chk("R10 ctrl unchanged", rd, 32'h8000_0001);
        wait_idle();
        repeat (40) @(negedge clk);
        chk("R10 pwr_on stays off", pwr_on, 0);
        chk("R10 iso_en stays on", iso_en, 1);
        chk("R10 busy idle", busy, 0);
        chk("R10 no pending items", sb.size(), 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule